// File: doc/BRIEF.md
# Sequential Signed Shift-Add Multiplier

This block multiplies two signed two's-complement words of width W (8 by default) using one shared adder/subtractor and a small register set: an accumulator, a multiplier shift register, a multiplicand register, a sticky sign flag and an iteration counter. A one-cycle `start` pulse while `done` is high begins an operation. The multiplicand is then taken from `in_bus` in the following cycle, and the multiplier in the cycle after that.

The unit examines one multiplier bit per step. For a 1 bit it adds the multiplicand into the accumulator. Each step ends with a right shift of the accumulator/multiplier pair, in which the sticky sign flag supplies the new accumulator top bit. After W-1 shifts, a set top multiplier bit causes one corrective subtraction, which is done as an add of the inverted multiplicand with carry-in 1. The double-width result leaves on `out_bus` in two consecutive cycles, high half first. It is in fractional alignment: the product shifted left by one, with bit 0 zero.

A hardwired eight-state controller sequences the work. A parameter chooses one-hot or binary state registers, and another chooses a ripple-carry or an inferred adder.

Top module: `smul_seq`

## Requirements
- R1: While reset is asserted and directly after it, `done` is 1, both strobes are 0 and `out_bus` is 0.
- R2: `start` sampled high while `done` is 1 makes `done` read 0 in the next cycle. `in_bus` is captured as the multiplicand in that cycle and as the multiplier in the cycle after it.
- R3: The result {high half, low half} equals (2 × a × b) mod 2^(2W) for signed a (multiplicand) and b (multiplier). The low half's bit 0 is always 0. For example, -128 × -128 gives 0x8000 and -1 × -1 gives 0x0002.
- R4: Each operation gives exactly one `out_hi_vld` cycle, then `out_lo_vld` in the very next cycle, then `done` high in the cycle after that.
- R5: The high half appears W+1+N cycles after the first cycle in which `done` reads 0, where N is the number of 1 bits in the multiplier.
- R6: `start` has no effect while `done` is 0.
- R7: `in_bus` has no effect outside the two load cycles.
- R8: `out_bus` is 0 in every cycle in which neither strobe is high.
- R9: At most one of `done`, `out_hi_vld` and `out_lo_vld` is high in any cycle.
- R10: The one-hot and binary controller variants, and the ripple and inferred adder variants, behave identically at the ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (only while idle) |
| in_bus | input | W | Multiplicand, then multiplier, on successive cycles |
| out_bus | output | W | Result half, zero when not strobed |
| out_hi_vld | output | 1 | `out_bus` carries the high half |
| out_lo_vld | output | 1 | `out_bus` carries the low half |
| done | output | 1 | Controller idle |

## Verification
A wrong accumulator, flag or shift value does not show at the ports until the result halves appear. The bench therefore compares every result against an independent signed reference, over every multiplicand against a set of multipliers that includes the extreme negative value. A wrong counter or a wrong next-state branch shifts the high-half strobe from its exact cycle, W+1+N, and that is checked in every operation. The low half then appears one cycle late at most, so a controller fault is caught within one operation. Two differently configured instances run in lockstep, and any difference at the ports between them is reported.

// File: rtl/smul_pkg.sv
package smul_pkg;

   localparam int NUM_ST = 8;

   // Controller states; index positions matter for the one-hot vector
   localparam int IX_IDLE = 0;
   localparam int IX_LDM  = 1;
   localparam int IX_LDQ  = 2;
   localparam int IX_ADD  = 3;
   localparam int IX_SHF  = 4;
   localparam int IX_SUB  = 5;
   localparam int IX_OUTH = 6;
   localparam int IX_OUTL = 7;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_LDM  = 3'd1,
      ST_LDQ  = 3'd2,
      ST_ADD  = 3'd3,
      ST_SHF  = 3'd4,
      ST_SUB  = 3'd5,
      ST_OUTH = 3'd6,
      ST_OUTL = 3'd7
   } smul_st_e;

   typedef struct packed {
      logic idle;      // controller waiting
      logic ld_m;      // clear acc/count/flag, capture multiplicand
      logic ld_q;      // capture multiplier
      logic alu_en;    // adder result into accumulator
      logic alu_sub;   // subtract and clear multiplier bit 0
      logic shift;     // pair shift and count
      logic drv_hi;    // accumulator onto output
      logic drv_lo;    // multiplier register onto output
   } smul_ctrl_t;

   function automatic smul_ctrl_t smul_decode(input logic [NUM_ST-1:0] sv);
      smul_ctrl_t c;
      c.idle    = sv[IX_IDLE];
      c.ld_m    = sv[IX_LDM];
      c.ld_q    = sv[IX_LDQ];
      c.alu_en  = sv[IX_ADD] | sv[IX_SUB];
      c.alu_sub = sv[IX_SUB];
      c.shift   = sv[IX_SHF];
      c.drv_hi  = sv[IX_OUTH];
      c.drv_lo  = sv[IX_OUTL];
      return c;
   endfunction

endpackage

// File: rtl/smul_addsub.sv
module smul_addsub #(
   parameter int W      = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   output logic [W-1:0] sum
);

   logic [W-1:0] b_x;

   assign b_x = sub ? ~b : b;

   generate
      if (RIPPLE) begin : g_ripple
         logic [W-1:0] cy;
         assign cy[0] = sub;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum[i] = a[i] ^ b_x[i] ^ cy[i];
            if (i < W - 1) begin : g_cy
               assign cy[i+1] = (a[i] & b_x[i]) | (cy[i] & (a[i] ^ b_x[i]));
            end
         end
      end else begin : g_infer
         assign sum = a + b_x + {{(W-1){1'b0}}, sub};
      end
   endgenerate

endmodule

// File: rtl/smul_ctrl.sv
module smul_ctrl
   import smul_pkg::*;
#(
   parameter bit ONE_HOT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       bit_ldq,   // multiplier bit 0 arriving on the bus
   input  logic       bit_nxt,   // multiplier bit that follows the shift
   input  logic       last,      // this shift is the final one
   output smul_ctrl_t ctrl
);

   logic [NUM_ST-1:0] sv;

   generate
      if (ONE_HOT) begin : g_onehot
         logic [NUM_ST-1:0] oh_q, oh_d;

         always_comb begin
            oh_d          = '0;
            oh_d[IX_IDLE] = (oh_q[IX_IDLE] & ~start) | oh_q[IX_OUTL];
            oh_d[IX_LDM]  = oh_q[IX_IDLE] & start;
            oh_d[IX_LDQ]  = oh_q[IX_LDM];
            oh_d[IX_ADD]  = (oh_q[IX_LDQ] & bit_ldq)
                          | (oh_q[IX_SHF] & ~last & bit_nxt);
            oh_d[IX_SHF]  = (oh_q[IX_LDQ] & ~bit_ldq) | oh_q[IX_ADD]
                          | (oh_q[IX_SHF] & ~last & ~bit_nxt);
            oh_d[IX_SUB]  = oh_q[IX_SHF] & last & bit_nxt;
            oh_d[IX_OUTH] = (oh_q[IX_SHF] & last & ~bit_nxt) | oh_q[IX_SUB];
            oh_d[IX_OUTL] = oh_q[IX_OUTH];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) oh_q <= NUM_ST'(1);
            else        oh_q <= oh_d;
         end

         assign sv = oh_q;
      end else begin : g_binary
         smul_st_e st_q, st_d;

         always_comb begin
            st_d = st_q;
            case (st_q)
               ST_IDLE: if (start) st_d = ST_LDM;
               ST_LDM:  st_d = ST_LDQ;
               ST_LDQ:  st_d = bit_ldq ? ST_ADD : ST_SHF;
               ST_ADD:  st_d = ST_SHF;
               ST_SHF: begin
                  if (last) st_d = bit_nxt ? ST_SUB : ST_OUTH;
                  else      st_d = bit_nxt ? ST_ADD : ST_SHF;
               end
               ST_SUB:  st_d = ST_OUTH;
               ST_OUTH: st_d = ST_OUTL;
               ST_OUTL: st_d = ST_IDLE;
               default: st_d = ST_IDLE;
            endcase
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= ST_IDLE;
            else        st_q <= st_d;
         end

         assign sv = NUM_ST'(1) << st_q;
      end
   endgenerate

   assign ctrl = smul_decode(sv);

endmodule

// File: rtl/smul_dpath.sv
module smul_dpath
   import smul_pkg::*;
#(
   parameter int W      = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  smul_ctrl_t   ctrl,
   input  logic [W-1:0] in_bus,
   output logic         bit_ldq,
   output logic         bit_nxt,
   output logic         last,
   output logic [W-1:0] out_bus
);

   localparam int CW = (W > 2) ? $clog2(W) : 1;
   localparam logic [CW-1:0] LAST_CNT = CW'(W - 2);

   logic [W-1:0]  acc, mq, mcand, sum;
   logic          flag;
   logic [CW-1:0] cnt;

   smul_addsub #(.W(W), .RIPPLE(RIPPLE)) addsub_i (
      .a   (acc),
      .b   (mcand),
      .sub (ctrl.alu_sub),
      .sum (sum)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc   <= '0;
         mq    <= '0;
         mcand <= '0;
         flag  <= 1'b0;
         cnt   <= '0;
      end else begin
         if (ctrl.ld_m) begin
            acc   <= '0;
            cnt   <= '0;
            flag  <= 1'b0;
            mcand <= in_bus;
         end
         if (ctrl.ld_q) mq <= in_bus;
         if (ctrl.alu_en) begin
            acc <= sum;
            if (ctrl.alu_sub) mq[0] <= 1'b0;
            else              flag  <= (mcand[W-1] & mq[0]) | flag;
         end
         if (ctrl.shift) begin
            acc <= {flag, acc[W-1:1]};
            mq  <= {acc[0], mq[W-1:1]};
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign bit_ldq = in_bus[0];
   assign bit_nxt = mq[1];
   assign last    = (cnt == LAST_CNT);

   always_comb begin
      if (ctrl.drv_hi)      out_bus = acc;
      else if (ctrl.drv_lo) out_bus = mq;
      else                  out_bus = '0;
   end

endmodule

// File: rtl/smul_seq.sv
module smul_seq
   import smul_pkg::*;
#(
   parameter int W       = 8,
   parameter bit ONE_HOT = 1'b1,
   parameter bit RIPPLE  = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] in_bus,
   output logic [W-1:0] out_bus,
   output logic         out_hi_vld,
   output logic         out_lo_vld,
   output logic         done
);

   generate
      if (W < 2) begin : g_bad_width
         $error("smul_seq: W must be at least 2");
      end
   endgenerate

   smul_ctrl_t ctrl;
   logic       bit_ldq, bit_nxt, last;

   smul_ctrl #(.ONE_HOT(ONE_HOT)) ctrl_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .bit_ldq (bit_ldq),
      .bit_nxt (bit_nxt),
      .last    (last),
      .ctrl    (ctrl)
   );

   smul_dpath #(.W(W), .RIPPLE(RIPPLE)) dpath_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctrl    (ctrl),
      .in_bus  (in_bus),
      .bit_ldq (bit_ldq),
      .bit_nxt (bit_nxt),
      .last    (last),
      .out_bus (out_bus)
   );

   assign out_hi_vld = ctrl.drv_hi;
   assign out_lo_vld = ctrl.drv_lo;
   assign done       = ctrl.idle;

endmodule

// File: rtl/smul_seq_chk.sv
module smul_seq_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic         done,
   input logic         out_hi_vld,
   input logic         out_lo_vld,
   input logic [W-1:0] out_bus
);

   // R2
   start_leaves_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && start) |=> !done);

   // R4
   lo_follows_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_hi_vld |=> out_lo_vld);

   // R4
   idle_after_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_lo_vld |=> done);

   // R8
   quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_hi_vld || out_lo_vld) |-> (out_bus == '0));

   // R9
   exclusive_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, out_hi_vld, out_lo_vld}));

   // R3
   lo_bit0_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_lo_vld |-> (out_bus[0] == 1'b0));

endmodule

bind smul_seq smul_seq_chk #(.W(W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .done       (done),
   .out_hi_vld (out_hi_vld),
   .out_lo_vld (out_lo_vld),
   .out_bus    (out_bus)
);

// File: tb/smul_seq_tb_top.sv
`timescale 1ns/1ps
module smul_seq_tb_top;

   localparam int W     = 8;
   localparam int NB    = 20;
   localparam int LIMIT = 190000;

   typedef struct {
      logic [2*W-1:0] prod;
      int             hi_cyc;
   } item_t;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         start;
   logic [W-1:0] in_bus;
   logic [W-1:0] out_bus, out_bus_b;
   logic         hi_v, lo_v, done, hi_v_b, lo_v_b, done_b;

   int    cyc = 0;
   int    n_chk = 0, n_err = 0;
   int    n_ops = 0, n_res = 0;
   int    r8_bad = 0, r10_bad = 0;
   bit    timeout = 0;
   bit    hi_prev = 0, after_lo = 0;
   logic [W-1:0] hi_val;
   item_t q_exp[$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   smul_seq #(.W(W), .ONE_HOT(1'b1), .RIPPLE(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .in_bus(in_bus),
      .out_bus(out_bus), .out_hi_vld(hi_v), .out_lo_vld(lo_v), .done(done));

   smul_seq #(.W(W), .ONE_HOT(1'b0), .RIPPLE(1'b0)) dut_bin_i (
      .clk(clk), .rst_n(rst_n), .start(start), .in_bus(in_bus),
      .out_bus(out_bus_b), .out_hi_vld(hi_v_b), .out_lo_vld(lo_v_b), .done(done_b));

   task automatic check(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [W-1:0] mult_pick(input int j);
      case (j)
         0: return 8'h00;   1: return 8'h01;   2: return 8'hFF;
         3: return 8'h02;   4: return 8'h7F;   5: return 8'h80;
         6: return 8'h81;   7: return 8'h40;   8: return 8'hC0;
         9: return 8'h55;  10: return 8'hAA;  11: return 8'h0F;
        12: return 8'hF0;  13: return 8'h3C;
         default: return W'((j * 37 + 11) & 8'hFF);
      endcase
   endfunction

   function automatic logic [2*W-1:0] ref_prod(input logic [W-1:0] a, input logic [W-1:0] b);
      int p;
      logic [31:0] pv;
      p  = int'($signed(a)) * int'($signed(b)) * 2;
      pv = p;
      return pv[2*W-1:0];
   endfunction

   task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input bit hold);
      item_t it;
      @(negedge clk);
      while (!done) @(negedge clk);
      start  = 1'b1;
      in_bus = W'($urandom);
      @(negedge clk);                       // first busy cycle: multiplicand load
      check(done == 1'b0, "R2 done low after start", 32'(done), 32'd0);
      it.prod   = ref_prod(a, b);
      it.hi_cyc = cyc + W + 1 + $countones(b);
      q_exp.push_back(it);
      n_ops++;
      start  = hold;                        // R6: start held high while busy
      in_bus = a;
      @(negedge clk);                       // multiplier load
      in_bus = b;
      @(negedge clk);
      start  = 1'b0;
      in_bus = W'($urandom);                // R7: garbage outside load cycles
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (!(hi_v || lo_v) && out_bus != '0) r8_bad++;
         if ({out_bus, hi_v, lo_v, done} != {out_bus_b, hi_v_b, lo_v_b, done_b}) r10_bad++;
         if (after_lo) begin
            check(done == 1'b1, "R4 done after low half", 32'(done), 32'd1);
            after_lo = 0;
         end
         if (hi_v) begin
            hi_val = out_bus;
            if (q_exp.size() == 0)
               check(1'b0, "R4 unexpected high half", 32'(hi_val), 32'd0);
            else
               check(cyc == q_exp[0].hi_cyc, "R5 high half cycle",
                     32'(cyc), 32'(q_exp[0].hi_cyc));
         end
         if (lo_v) begin
            check(hi_prev, "R4 low half follows high half", 32'(hi_prev), 32'd1);
            if (q_exp.size() != 0) begin
               item_t it;
               it = q_exp.pop_front();
               check({hi_val, out_bus} == it.prod, "R3 R7 product",
                     32'({hi_val, out_bus}), 32'(it.prod));
            end
            n_res++;
            after_lo = 1;
         end
         hi_prev = hi_v;
      end
   end

   initial begin
      rst_n  = 1'b0;
      start  = 1'b0;
      in_bus = '0;
      repeat (3) @(negedge clk);
      check(done == 1'b1 && !hi_v && !lo_v && out_bus == '0, "R1 in reset",
            {done, hi_v, lo_v, 21'd0, out_bus}, 32'h8000_0000);
      rst_n = 1'b1;
      @(negedge clk);
      check(done == 1'b1 && !hi_v && !lo_v && out_bus == '0, "R1 after reset",
            {done, hi_v, lo_v, 21'd0, out_bus}, 32'h8000_0000);

      fork
         begin
            for (int j = 0; j < NB; j++) begin
               for (int a = 0; a < 256; a++) begin
                  run_op(W'(a), mult_pick(j), (a % 7) == 3);
               end
            end
            @(negedge clk);
            while (!done) @(negedge clk);
            repeat (3) @(negedge clk);
         end
         begin
            repeat (LIMIT) @(posedge clk);
            timeout = 1;
         end
      join_any
      disable fork;

      check(!timeout, "watchdog expired", 32'(timeout), 32'd0);
      check(n_res == n_ops && q_exp.size() == 0, "R6 R4 one result per operation",
            32'(n_res), 32'(n_ops));
      check(r8_bad == 0, "R8 bus idle when not strobed", 32'(r8_bad), 32'd0);
      check(r10_bad == 0, "R10 variants in lockstep", 32'(r10_bad), 32'd0);
      // R9 is covered by exclusive_flags_chk in the bound checker

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule